// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel of a general-purpose timer. It contains a free-running up-counter, advanced by a prescaler, and a 16-bit compare value that a byte-wide processor bus writes as two separately addressed bytes. The first bus cycle in which the counter holds a new value equal to the compare value is a match. A match sets a sticky status flag. If output driving is enabled, the same match copies a programmed level bit onto the compare pin. The interrupt request is the flag gated by an enable bit.

The compare value is updated as a whole in two steps. Writing the upper byte suspends matching, so a half-written value can never fire. Writing the lower byte loads that byte and resumes matching. A write to the lower byte alone never suspends anything. Software clears the flag in two steps: it reads the status register while the flag is set, then writes the lower compare byte. That write normally sets up the next timeout at the same time.

Top module: `ocmp_channel`

## Requirements
- R1: Reset sets the counter to 0. After reset the counter increases by exactly one every PRESCALE (default 4) clocks. Reading address 4 returns the counter's upper byte and address 5 its lower byte.
- R2: Address 0 holds the upper compare byte and address 1 the lower. Both read back. A write to either byte leaves the other byte unchanged.
- R3: A match occurs when, in the first clock cycle after the counter takes a new value, that value equals the compare value and matching is enabled. The status flag (address 2, bit 0) is set at the end of that cycle. Each counter value can produce at most one match.
- R4: A write to address 0 disables matching from the next cycle onward. Matching stays disabled until address 1 is written.
- R5: A write to address 1 enables matching from the next cycle onward, whether or not address 0 was written before it.
- R6: After reset, matching is disabled. The flag, the pin, both compare bytes and the control register (address 3) all read 0.
- R7: On a match with output enable set (control bit 1), the level bit (control bit 2) is copied to `cmp_pin_o` on the same edge that sets the flag. This happens whether the flag was already set or not. At any other time the pin holds its value.
- R8: `irq_o` is high exactly while the flag and the interrupt enable (control bit 0) are both set.
- R9: The flag is cleared by a write to address 1 only if a status read found the flag set after the previous write to address 1. A write to address 1 without such a read leaves the flag set.
- R10: If a match and a clearing write to address 1 fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_addr_i | input | 3 | Register select |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the strobe cycle, 0 when no read |
| cmp_pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to produce from the ports is R10. The clearing write must land in exactly the one cycle in which the counter has just stepped onto the compare value. By then the flag must already be set, and a status read must have armed the clear. The stimulus reaches this state in four steps:
1. Let one match set the flag.
2. Load a new compare value a few counts ahead. This lower-byte write has no read before it, so it leaves the flag set.
3. Read the status register to arm the clear.
4. Idle, watching the bench's own model of the prescaler and counter, and issue the lower-byte write in the predicted match cycle.

Random writes aimed a few counts ahead of the counter then mix upper-only, lower-only and paired writes around live matches.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMP_HI = 3'd0,
    REG_CMP_LO = 3'd1,
    REG_STATUS = 3'd2,
    REG_CTRL   = 3'd3,
    REG_CNT_HI = 3'd4,
    REG_CNT_LO = 3'd5
  } reg_sel_e;

  localparam int CTRL_IE   = 0;
  localparam int CTRL_OE   = 1;
  localparam int CTRL_LVL  = 2;
  localparam int STAT_FLAG = 0;

  typedef struct packed {
    logic lvl;
    logic oe;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/ocmp_timebase.sv
module ocmp_timebase #(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fresh_o
);
  logic             step;
  logic [CNT_W-1:0] cnt_q;
  logic             fresh_q;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   pre_q <= '0;
        else if (step) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
      end
      assign step = (pre_q == PW'(PRESCALE - 1));
    end else begin : g_nodiv
      assign step = 1'b1;
    end
  endgenerate

  // fresh marks the first cycle of each counter value; reset value counts as new
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      if (step) cnt_q <= cnt_q + 1'b1;
      fresh_q <= step;
    end
  end

  assign cnt_o   = cnt_q;
  assign fresh_o = fresh_q;
endmodule

// File: rtl/ocmp_cmp_reg.sv
module ocmp_cmp_reg #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              match_en_o
);
  logic [DATA_W-1:0] hi_q, lo_q;
  logic              inh_q;

  // inhibit starts set: no match until the first low-byte write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      inh_q <= 1'b1;
    end else begin
      if (wr_hi_i) begin
        hi_q  <= wdata_i;
        inh_q <= 1'b1;
      end
      if (wr_lo_i) begin
        lo_q  <= wdata_i;
        inh_q <= 1'b0;
      end
    end
  end

  assign cmp_o      = {hi_q, lo_q};
  assign match_en_o = ~inh_q;
endmodule

// File: rtl/ocmp_event.sv
module ocmp_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic clr_wr_i,
  input  logic stat_rd_i,
  input  logic oe_i,
  input  logic lvl_i,
  output logic flag_o,
  output logic pin_o
);
  logic flag_q, arm_q, pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
      pin_q  <= 1'b0;
    end else begin
      if (clr_wr_i)                 arm_q <= 1'b0;
      else if (stat_rd_i && flag_q) arm_q <= 1'b1;

      // a match outranks the clear
      if (match_i)                 flag_q <= 1'b1;
      else if (clr_wr_i && arm_q)  flag_q <= 1'b0;

      if (match_i && oe_i) pin_q <= lvl_i;
    end
  end

  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int DATA_W   = 8,
  parameter int PRESCALE = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       bus_wr_i,
  input  logic                       bus_rd_i,
  input  logic [ocmp_pkg::ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic                       cmp_pin_o,
  output logic                       irq_o
);
  import ocmp_pkg::*;
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0] cnt_q, cmp_val;
  logic             cnt_fresh, match_en, match, flag_q;
  logic             wr_hi, wr_lo, wr_ctrl, rd_stat;
  ctrl_t            ctrl_q;
  logic [DATA_W-1:0] rd_mux;

  assign wr_hi   = bus_wr_i && (bus_addr_i == REG_CMP_HI);
  assign wr_lo   = bus_wr_i && (bus_addr_i == REG_CMP_LO);
  assign wr_ctrl = bus_wr_i && (bus_addr_i == REG_CTRL);
  assign rd_stat = bus_rd_i && (bus_addr_i == REG_STATUS);

  ocmp_timebase #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_tb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cnt_o   (cnt_q),
    .fresh_o (cnt_fresh)
  );

  ocmp_cmp_reg #(.DATA_W(DATA_W)) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hi_i    (wr_hi),
    .wr_lo_i    (wr_lo),
    .wdata_i    (bus_wdata_i),
    .cmp_o      (cmp_val),
    .match_en_o (match_en)
  );

  assign match = cnt_fresh && match_en && (cnt_q == cmp_val);

  ocmp_event u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (match),
    .clr_wr_i  (wr_lo),
    .stat_rd_i (rd_stat),
    .oe_i      (ctrl_q.oe),
    .lvl_i     (ctrl_q.lvl),
    .flag_o    (flag_q),
    .pin_o     (cmp_pin_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'({bus_wdata_i[CTRL_LVL], bus_wdata_i[CTRL_OE],
                                          bus_wdata_i[CTRL_IE]});
  end

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr_i)
      REG_CMP_HI: rd_mux = cmp_val[CNT_W-1:DATA_W];
      REG_CMP_LO: rd_mux = cmp_val[DATA_W-1:0];
      REG_STATUS: rd_mux[STAT_FLAG] = flag_q;
      REG_CTRL: begin
        rd_mux[CTRL_IE]  = ctrl_q.ie;
        rd_mux[CTRL_OE]  = ctrl_q.oe;
        rd_mux[CTRL_LVL] = ctrl_q.lvl;
      end
      REG_CNT_HI: rd_mux = cnt_q[CNT_W-1:DATA_W];
      REG_CNT_LO: rd_mux = cnt_q[DATA_W-1:0];
      default:    rd_mux = '0;
    endcase
  end

  assign bus_rdata_o = bus_rd_i ? rd_mux : '0;
  assign irq_o       = flag_q & ctrl_q.ie;
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_i,
  input logic             fresh_i,
  input logic             match_en_i,
  input logic             wr_hi_i,
  input logic             wr_lo_i,
  input logic             oe_i,
  input logic             flag_i,
  input logic             pin_i
);
  logic hit;
  assign hit = fresh_i && match_en_i && (cnt_i == cmp_i);

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> cnt_i == $past(cnt_i) + 1'b1);                       // R1
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> cmp_i[DATA_W-1:0] == $past(cmp_i[DATA_W-1:0]));              // R2
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(hit));                                           // R3
  AST_HI_INHIBITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> !match_en_i);                                                // R4
  AST_LO_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> match_en_i);                                                 // R5
  AST_PIN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pin_i) |-> $past(hit && oe_i));                                 // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(wr_lo_i));                                       // R9
  AST_MATCH_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_i);                                                         // R10
endmodule

bind ocmp_channel ocmp_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_i      (cnt_q),
  .cmp_i      (cmp_val),
  .fresh_i    (cnt_fresh),
  .match_en_i (match_en),
  .wr_hi_i    (wr_hi),
  .wr_lo_i    (wr_lo),
  .oe_i       (ctrl_q.oe),
  .flag_i     (flag_q),
  .pin_i      (cmp_pin_o)
);

// File: tb/ocmp_channel_tb_top.sv
module ocmp_channel_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic       pin, irq;

  always #2 clk = ~clk;

  ocmp_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rdata),
    .cmp_pin_o(pin), .irq_o(irq)
  );

  int n_vec = 0;
  int n_err = 0;

  // reference model state
  int          m_pre;
  logic [15:0] m_cnt, m_cmp;
  logic        m_fresh, m_inh, m_flag, m_arm, m_pin, m_ie, m_oe, m_lvl;

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0:    return m_cmp[15:8];
      3'd1:    return m_cmp[7:0];
      3'd2:    return {7'b0, m_flag};
      3'd3:    return {5'b0, m_lvl, m_oe, m_ie};
      3'd4:    return m_cnt[15:8];
      3'd5:    return m_cnt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_hit();
    return m_fresh && !m_inh && (m_cnt == m_cmp);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_cycle(input logic w, input logic r, input logic [2:0] a,
                           input logic [7:0] d, input string tag);
    logic        hit, stp;
    int          n_pre;
    logic [15:0] n_cnt, n_cmp;
    logic        n_inh, n_flag, n_arm, n_pin;
    wr = w; rd = r; addr = a; wd = d;
    #1;
    if (r) check(tag, rdata, exp_rd(a));
    hit   = model_hit();
    stp   = (m_pre == 3);
    n_pre = stp ? 0 : m_pre + 1;
    n_cnt = m_cnt + {15'b0, stp};
    n_cmp = m_cmp; n_inh = m_inh;
    if (w && a == 3'd0) begin n_cmp[15:8] = d; n_inh = 1'b1; end
    if (w && a == 3'd1) begin n_cmp[7:0]  = d; n_inh = 1'b0; end
    n_arm  = (w && a == 3'd1) ? 1'b0 : ((r && a == 3'd2 && m_flag) ? 1'b1 : m_arm);
    n_flag = hit ? 1'b1 : ((w && a == 3'd1 && m_arm) ? 1'b0 : m_flag);
    n_pin  = (hit && m_oe) ? m_lvl : m_pin;
    @(posedge clk);
    m_pre = n_pre; m_cnt = n_cnt; m_fresh = stp; m_cmp = n_cmp; m_inh = n_inh;
    m_arm = n_arm; m_flag = n_flag; m_pin = n_pin;
    if (w && a == 3'd3) {m_lvl, m_oe, m_ie} = d[2:0];
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    check("R7 pin", {7'b0, pin}, {7'b0, m_pin});
    check("R8 irq", {7'b0, irq}, {7'b0, m_flag & m_ie});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus_cycle(1'b0, 1'b0, 3'd0, 8'h00, "idle");
  endtask

  task automatic set_cmp(input logic [15:0] v);
    bus_cycle(1'b1, 1'b0, 3'd0, v[15:8], "R2");
    bus_cycle(1'b1, 1'b0, 3'd1, v[7:0], "R2");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [15:0] t;
    int          guard;
    void'($urandom(32'h0C5E_ED01));
    m_pre = 0; m_cnt = '0; m_cmp = '0; m_fresh = 1'b1; m_inh = 1'b1;
    m_flag = 1'b0; m_arm = 1'b0; m_pin = 1'b0; m_ie = 1'b0; m_oe = 1'b0; m_lvl = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6: reset values
    check("R6 pin", {7'b0, pin}, 8'h00);
    check("R6 irq", {7'b0, irq}, 8'h00);
    for (int a = 0; a < 4; a++) bus_cycle(1'b0, 1'b1, 3'(a), 8'h00, "R6");
    // R1: counter readback
    idle(9);
    bus_cycle(1'b0, 1'b1, 3'd5, 8'h00, "R1");
    bus_cycle(1'b0, 1'b1, 3'd4, 8'h00, "R1");

    // R3/R7/R8: basic match with pin drive and interrupt
    bus_cycle(1'b1, 1'b0, 3'd3, 8'h07, "R8");
    t = m_cnt + 16'd4;
    set_cmp(t);
    idle(24);
    // R9: low write with no prior status read keeps flag
    bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R9");
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R9");
    bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R9");
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R9");

    // R4: high write alone suppresses a would-be match; pin must not drop
    bus_cycle(1'b1, 1'b0, 3'd3, 8'h03, "R4");
    t = m_cnt + 16'd6;
    bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R4");
    bus_cycle(1'b1, 1'b0, 3'd0, t[15:8], "R4");
    idle(30);
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R4");

    // R5: low-only write re-arms compare
    t = m_cnt + 16'd3;
    bus_cycle(1'b1, 1'b0, 3'd0, t[15:8], "R5");
    bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R5");
    t = m_cnt + 16'd5;
    if (t[15:8] == m_cmp[15:8]) bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R5");
    idle(28);
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R5");

    // R7: output disabled, pin must hold across a match
    bus_cycle(1'b1, 1'b0, 3'd3, 8'h05, "R7");
    set_cmp(m_cnt + 16'd4);
    idle(24);

    // R10: clearing write coincides with a match
    bus_cycle(1'b1, 1'b0, 3'd3, 8'h07, "R10");
    set_cmp(m_cnt + 16'd4);
    idle(24);
    t = m_cnt + 16'd6;
    set_cmp(t);
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R10");
    guard = 0;
    while (!model_hit() && guard < 100) begin
      idle(1);
      guard++;
    end
    bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R10");
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R10");
    // and a plain clear afterwards
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R9");
    bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R9");
    bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R9");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int op;
      op = int'($urandom % 8);
      t  = m_cnt + 16'(1 + $urandom % 10);
      case (op)
        0: set_cmp(t);
        1: bus_cycle(1'b1, 1'b0, 3'd0, t[15:8], "R4");
        2: bus_cycle(1'b1, 1'b0, 3'd1, t[7:0], "R5");
        3: bus_cycle(1'b0, 1'b1, 3'd2, 8'h00, "R3");
        4: bus_cycle(1'b1, 1'b0, 3'd3, 8'($urandom), "R8");
        5: bus_cycle(1'b0, 1'b1, 3'($urandom), 8'h00, "R2");
        default: idle(1 + int'($urandom % 4));
      endcase
    end
    bus_cycle(1'b0, 1'b1, 3'd4, 8'h00, "R1");
    bus_cycle(1'b0, 1'b1, 3'd5, 8'h00, "R1");
    finish_run();
  end
endmodule